// File: doc/BRIEF.md
# Instruction Fetch Tag Tracker

This block sits between a warp scheduler and an instruction cache. Each cycle it can take one scheduled instruction record: a warp id, a program counter and a flag that marks a fetch stall. As soon as it takes a record it raises a suspend pulse for that warp. It holds the record in a one-entry fetch latch until a tag is free. It then stores the record in a small tag table and sends a cache read, addressed by the program counter and labelled with the tag.

Cache responses may come back in any order. The returned tag selects the stored record, frees the tag and moves the record into a one-entry decode latch. Decode pushes the record into that warp's instruction buffer. When the push succeeds, decode pulses a resume for the warp, unless the record carries the fetch-stall flag. If the warp's buffer is full, decode holds the record and counts one stall cycle for each cycle it waits.

Three counters run alongside the pipeline. One holds the number of outstanding fetches. One accumulates that number every cycle, which gives a measure of fetch latency. One counts decode stall cycles.

Top module: `ifetch_tag_tracker`

## Requirements
- R1: After reset, `sched_ready` is 1, `icache_req_valid` is 0, all three counters are 0 and every instruction buffer is empty.
- R2: In the cycle a record is accepted (`sched_valid` and `sched_ready` both high), `warp_suspend_valid` is 1 and `warp_suspend_wid` equals `sched_wid`.
- R3: In the cycle after acceptance, if a tag is free, `icache_req_valid` is 1, `icache_req_addr` equals the record's PC and `icache_req_tag` is the lowest-numbered free tag.
- R4: While every tag is outstanding, no request is issued. The fetch latch keeps its record, and `sched_ready` stays 0 while the latch is occupied.
- R5: A response with tag T sends the record stored under T to the instruction buffer of that record's warp, even when responses arrive out of order. Tag T can then be allocated again.
- R6: `pending_fetches` rises by one on each accepted request and falls by one on each accepted response. It never exceeds the number of tags.
- R7: On every clock edge, `fetch_latency_acc` grows by the value `pending_fetches` had before that edge.
- R8: While the record in the decode latch targets a full buffer, `decode_stall_count` rises by one per cycle, no resume is issued and `icache_rsp_ready` is 0.
- R9: When decode pushes a record, `warp_resume_valid` pulses in that cycle with the record's warp id. It stays 0 if the record's fetch-stall flag is 1.
- R10: Each warp's buffer returns PCs in the order they were pushed. `ibuf_pop` bit w removes the head entry of warp w.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sched_valid | input | 1 | Scheduled record present |
| sched_ready | output | 1 | Fetch latch can take a record |
| sched_wid | input | WID_W | Warp id of the record |
| sched_pc | input | PC_W | Instruction address |
| sched_fetch_stall | input | 1 | Record must not resume its warp at decode |
| warp_suspend_valid | output | 1 | Suspend pulse |
| warp_suspend_wid | output | WID_W | Warp to suspend |
| icache_req_valid | output | 1 | Cache read request valid |
| icache_req_ready | input | 1 | Cache accepts the request |
| icache_req_addr | output | PC_W | Read address |
| icache_req_tag | output | TAG_W | Request tag |
| icache_rsp_valid | input | 1 | Cache response valid |
| icache_rsp_ready | output | 1 | Decode latch can take a response |
| icache_rsp_tag | input | TAG_W | Tag of the returning fetch |
| warp_resume_valid | output | 1 | Resume pulse |
| warp_resume_wid | output | WID_W | Warp to resume |
| ibuf_pop | input | NUM_WARPS | Per-warp buffer pop |
| ibuf_nonempty | output | NUM_WARPS | Per-warp buffer holds entries |
| ibuf_head_pc | output | NUM_WARPS*PC_W | Head PC of each warp buffer, warp w at bits [w*PC_W +: PC_W] |
| pending_fetches | output | CNT_W | Outstanding fetch count |
| fetch_latency_acc | output | ACC_W | Per-cycle sum of the outstanding count |
| decode_stall_count | output | ACC_W | Cycles decode waited on a full buffer |

## Verification
The suspend pulse comes from logic with no register in its path, so it is checked in the same cycle as the scheduling handshake. The cache request appears one edge after acceptance. A response reaches the decode latch one edge after the response handshake; the resume pulse is visible in that cycle, and the buffer head one edge later. The bench drives inputs at the falling edge and samples a moment later, so every check looks at the cycle worked out from this register count. The bench predicts the counters from the handshakes it sees at the ports and sums them edge by edge, just as R6 and R7 describe.

// File: rtl/ift_pkg.sv
package ift_pkg;

  // Index of the lowest set bit, 0 when none is set.
  function automatic int unsigned lowest_set(input logic [63:0] v);
    int unsigned idx;
    idx = 0;
    for (int i = 63; i >= 0; i--) begin
      if (v[i]) idx = i;
    end
    return idx;
  endfunction

  // Next value of an up/down count.
  function automatic int unsigned step_count(input int unsigned cur,
                                             input logic up, input logic down);
    return cur + (up ? 1 : 0) - (down ? 1 : 0);
  endfunction

endpackage

// File: rtl/ift_tag_table.sv
module ift_tag_table #(
  parameter int TAGS  = 4,
  parameter int REC_W = 8,
  localparam int TAG_W = (TAGS > 1) ? $clog2(TAGS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_en,
  input  logic [REC_W-1:0] alloc_rec,
  output logic             has_free,
  output logic [TAG_W-1:0] alloc_tag,
  input  logic             free_en,
  input  logic [TAG_W-1:0] free_tag,
  output logic [REC_W-1:0] free_rec,
  output logic [TAGS-1:0]  busy
);
  import ift_pkg::*;

  logic [REC_W-1:0] store [TAGS];
  logic [TAGS-1:0]  alloc_mask, free_mask;

  always_comb begin
    has_free  = ~&busy;
    alloc_tag = TAG_W'(lowest_set(64'(~busy)));
    free_rec  = store[free_tag];
  end

  generate
    for (genvar t = 0; t < TAGS; t++) begin : g_slot
      assign alloc_mask[t] = alloc_en && (alloc_tag == TAG_W'(t));
      assign free_mask[t]  = free_en && (free_tag == TAG_W'(t));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          busy[t]  <= 1'b0;
          store[t] <= '0;
        end else begin
          if (alloc_mask[t]) begin
            busy[t]  <= 1'b1;
            store[t] <= alloc_rec;
          end else if (free_mask[t]) begin
            busy[t] <= 1'b0;
          end
        end
      end
    end
  endgenerate

endmodule

// File: rtl/ift_warp_ibuf.sv
module ift_warp_ibuf #(
  parameter int DEPTH = 2,
  parameter int PC_W  = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [PC_W-1:0] push_pc,
  input  logic            pop,
  output logic            nonempty,
  output logic            full,
  output logic [PC_W-1:0] head_pc
);
  logic [PC_W-1:0]  mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic [CNT_W-1:0] count;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign nonempty = (count != '0);
  assign full     = (count == CNT_W'(DEPTH));
  assign head_pc  = mem[rd_ptr];
  assign do_push  = push && !full;
  assign do_pop   = pop && nonempty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (do_push) begin
        mem[wr_ptr] <= push_pc;
        wr_ptr      <= bump(wr_ptr);
      end
      if (do_pop) rd_ptr <= bump(rd_ptr);
      count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

endmodule

// File: rtl/ift_fetch_counters.sv
module ift_fetch_counters #(
  parameter int CNT_W = 3,
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_fire,
  input  logic             rsp_fire,
  input  logic             dec_stall,
  output logic [CNT_W-1:0] pending,
  output logic [ACC_W-1:0] latency_acc,
  output logic [ACC_W-1:0] stall_count
);
  import ift_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending     <= '0;
      latency_acc <= '0;
      stall_count <= '0;
    end else begin
      pending     <= CNT_W'(step_count(int'(pending), req_fire, rsp_fire));
      latency_acc <= latency_acc + ACC_W'(pending);
      if (dec_stall) stall_count <= stall_count + 1'b1;
    end
  end

endmodule

// File: rtl/ifetch_tag_tracker.sv
module ifetch_tag_tracker #(
  parameter int NUM_WARPS  = 8,
  parameter int TAGS       = 4,
  parameter int IBUF_DEPTH = 2,
  parameter int PC_W       = 32,
  parameter int ACC_W      = 32,
  localparam int WID_W = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
  localparam int TAG_W = (TAGS > 1) ? $clog2(TAGS) : 1,
  localparam int CNT_W = $clog2(TAGS + 1),
  localparam int REC_W = WID_W + PC_W + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sched_valid,
  output logic                      sched_ready,
  input  logic [WID_W-1:0]          sched_wid,
  input  logic [PC_W-1:0]           sched_pc,
  input  logic                      sched_fetch_stall,
  output logic                      warp_suspend_valid,
  output logic [WID_W-1:0]          warp_suspend_wid,
  output logic                      icache_req_valid,
  input  logic                      icache_req_ready,
  output logic [PC_W-1:0]           icache_req_addr,
  output logic [TAG_W-1:0]          icache_req_tag,
  input  logic                      icache_rsp_valid,
  output logic                      icache_rsp_ready,
  input  logic [TAG_W-1:0]          icache_rsp_tag,
  output logic                      warp_resume_valid,
  output logic [WID_W-1:0]          warp_resume_wid,
  input  logic [NUM_WARPS-1:0]      ibuf_pop,
  output logic [NUM_WARPS-1:0]      ibuf_nonempty,
  output logic [NUM_WARPS*PC_W-1:0] ibuf_head_pc,
  output logic [CNT_W-1:0]          pending_fetches,
  output logic [ACC_W-1:0]          fetch_latency_acc,
  output logic [ACC_W-1:0]          decode_stall_count
);

  // Record layout: {fetch_stall, wid, pc}
  function automatic logic [REC_W-1:0] pack_rec(input logic fs,
      input logic [WID_W-1:0] w, input logic [PC_W-1:0] pc);
    return {fs, w, pc};
  endfunction

  logic [REC_W-1:0] fl_rec, dl_rec, tbl_rd_rec;
  logic             fl_v, dl_v;
  logic             sched_fire, req_fire, rsp_fire;
  logic             has_free;
  logic [TAG_W-1:0] alloc_tag;
  logic [TAGS-1:0]  tag_busy;
  logic [NUM_WARPS-1:0] ibuf_full, ibuf_push;
  logic [WID_W-1:0] dl_wid;
  logic [PC_W-1:0]  dl_pc;
  logic             dl_fs;
  logic             dec_accept, dec_stall;

  // Schedule / fetch latch
  assign sched_ready        = !fl_v || req_fire;
  assign sched_fire         = sched_valid && sched_ready;
  assign warp_suspend_valid = sched_fire;
  assign warp_suspend_wid   = sched_wid;

  assign icache_req_valid = fl_v && has_free;
  assign icache_req_addr  = fl_rec[PC_W-1:0];
  assign icache_req_tag   = alloc_tag;
  assign req_fire         = icache_req_valid && icache_req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl_v   <= 1'b0;
      fl_rec <= '0;
    end else if (sched_fire) begin
      fl_v   <= 1'b1;
      fl_rec <= pack_rec(sched_fetch_stall, sched_wid, sched_pc);
    end else if (req_fire) begin
      fl_v <= 1'b0;
    end
  end

  ift_tag_table #(.TAGS(TAGS), .REC_W(REC_W)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .alloc_en(req_fire), .alloc_rec(fl_rec),
    .has_free(has_free), .alloc_tag(alloc_tag),
    .free_en(rsp_fire), .free_tag(icache_rsp_tag),
    .free_rec(tbl_rd_rec), .busy(tag_busy)
  );

  // Response / decode latch
  assign {dl_fs, dl_wid, dl_pc} = dl_rec;
  assign dec_accept       = dl_v && !ibuf_full[dl_wid];
  assign dec_stall        = dl_v && ibuf_full[dl_wid];
  assign icache_rsp_ready = !dl_v || dec_accept;
  assign rsp_fire         = icache_rsp_valid && icache_rsp_ready;

  assign warp_resume_valid = dec_accept && !dl_fs;
  assign warp_resume_wid   = dl_wid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dl_v   <= 1'b0;
      dl_rec <= '0;
    end else if (rsp_fire) begin
      dl_v   <= 1'b1;
      dl_rec <= tbl_rd_rec;
    end else if (dec_accept) begin
      dl_v <= 1'b0;
    end
  end

  // Per-warp instruction buffers
  generate
    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_ibuf
      assign ibuf_push[w] = dec_accept && (dl_wid == WID_W'(w));
      ift_warp_ibuf #(.DEPTH(IBUF_DEPTH), .PC_W(PC_W)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .push(ibuf_push[w]), .push_pc(dl_pc),
        .pop(ibuf_pop[w]),
        .nonempty(ibuf_nonempty[w]), .full(ibuf_full[w]),
        .head_pc(ibuf_head_pc[w*PC_W +: PC_W])
      );
    end
  endgenerate

  ift_fetch_counters #(.CNT_W(CNT_W), .ACC_W(ACC_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .req_fire(req_fire), .rsp_fire(rsp_fire), .dec_stall(dec_stall),
    .pending(pending_fetches), .latency_acc(fetch_latency_acc),
    .stall_count(decode_stall_count)
  );

endmodule

// File: rtl/ifetch_tag_tracker_chk.sv
module ifetch_tag_tracker_chk #(
  parameter int TAGS  = 4,
  parameter int TAG_W = 2,
  parameter int CNT_W = 3,
  parameter int ACC_W = 32,
  parameter int REC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [TAG_W-1:0] req_tag,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [TAG_W-1:0] rsp_tag,
  input logic [TAGS-1:0]  busy,
  input logic             fl_v,
  input logic             sched_ready,
  input logic             dl_v,
  input logic [REC_W-1:0] dl_rec,
  input logic             dec_accept,
  input logic             resume_valid,
  input logic [CNT_W-1:0] pending,
  input logic [ACC_W-1:0] acc
);
  // R3: an issued tag is one that is currently free
  a_r3_tag_free: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !busy[req_tag]);

  // R4: no request and no new record while every tag is outstanding
  a_r4_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (&busy) && fl_v |-> !req_valid && !sched_ready);

  // R5: a response names an outstanding tag
  a_r5_rsp_known_tag: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready |-> busy[rsp_tag]);

  // R6: outstanding count tracks the handshakes and stays bounded
  a_r6_pending_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> int'(pending) == int'($past(pending))
      + ($past(req_valid && req_ready) ? 1 : 0)
      - ($past(rsp_valid && rsp_ready) ? 1 : 0));
  a_r6_pending_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pending) <= TAGS);

  // R7: accumulator sums the outstanding count
  a_r7_acc_sum: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> acc == $past(acc) + ACC_W'($past(pending)));

  // R8: a stalled decode record is held unchanged
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    dl_v && !dec_accept |=> dl_v && $stable(dl_rec));

  // R9: resume only with a decode push
  a_r9_resume_push: assert property (@(posedge clk) disable iff (!rst_n)
    resume_valid |-> dl_v && dec_accept);

endmodule

bind ifetch_tag_tracker ifetch_tag_tracker_chk #(
  .TAGS(TAGS), .TAG_W(TAG_W), .CNT_W(CNT_W), .ACC_W(ACC_W), .REC_W(REC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .req_valid(icache_req_valid), .req_ready(icache_req_ready),
  .req_tag(icache_req_tag),
  .rsp_valid(icache_rsp_valid), .rsp_ready(icache_rsp_ready),
  .rsp_tag(icache_rsp_tag),
  .busy(tag_busy), .fl_v(fl_v), .sched_ready(sched_ready),
  .dl_v(dl_v), .dl_rec(dl_rec), .dec_accept(dec_accept),
  .resume_valid(warp_resume_valid),
  .pending(pending_fetches), .acc(fetch_latency_acc)
);

// File: tb/tb_ifetch_tag_tracker.sv
module tb_ifetch_tag_tracker;
  localparam int NW = 8, TAGS = 4, DEPTH = 2, PC_W = 32, ACC_W = 32;
  localparam int WID_W = 3, TAG_W = 2, CNT_W = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sched_valid = 0, sched_fetch_stall = 0;
  logic [WID_W-1:0] sched_wid = '0;
  logic [PC_W-1:0] sched_pc = '0;
  logic icache_req_ready = 1, icache_rsp_valid = 0;
  logic [TAG_W-1:0] icache_rsp_tag = '0;
  logic [NW-1:0] ibuf_pop = '0;
  logic sched_ready, warp_suspend_valid, icache_req_valid, icache_rsp_ready;
  logic warp_resume_valid;
  logic [WID_W-1:0] warp_suspend_wid, warp_resume_wid;
  logic [PC_W-1:0] icache_req_addr;
  logic [TAG_W-1:0] icache_req_tag;
  logic [NW-1:0] ibuf_nonempty;
  logic [NW*PC_W-1:0] ibuf_head_pc;
  logic [CNT_W-1:0] pending_fetches;
  logic [ACC_W-1:0] fetch_latency_acc, decode_stall_count;

  int n_chk = 0, n_bad = 0;
  int exp_pend = 0;
  longint exp_acc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ifetch_tag_tracker #(.NUM_WARPS(NW), .TAGS(TAGS), .IBUF_DEPTH(DEPTH),
                       .PC_W(PC_W), .ACC_W(ACC_W)) dut (.*);

  // Counter model from port handshakes
  always @(posedge clk) begin
    if (rst_n) begin
      exp_acc  <= exp_acc + exp_pend;
      exp_pend <= exp_pend + ((icache_req_valid && icache_req_ready) ? 1 : 0)
                           - ((icache_rsp_valid && icache_rsp_ready) ? 1 : 0);
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  function automatic logic [PC_W-1:0] head(input int w);
    return ibuf_head_pc[w*PC_W +: PC_W];
  endfunction

  task automatic fetch_one(input int w, input logic [PC_W-1:0] pc, input bit fs, input int tag);
    sched_valid = 1; sched_wid = WID_W'(w); sched_pc = pc; sched_fetch_stall = fs;
    #1;
    chk(sched_ready && warp_suspend_valid, "R2 suspend", warp_suspend_valid, 1);
    chk(warp_suspend_wid == WID_W'(w), "R2 wid", warp_suspend_wid, w);
    step(); sched_valid = 0; #1;
    chk(icache_req_valid && icache_req_addr == pc, "R3 addr", icache_req_addr, pc);
    chk(icache_req_tag == TAG_W'(tag), "R3 lowest tag", icache_req_tag, tag);
    step();
  endtask

  task automatic respond(input int tag, input int w, input logic [PC_W-1:0] hpc,
                         input bit res, input bit chk_head);
    icache_rsp_valid = 1; icache_rsp_tag = TAG_W'(tag); #1;
    chk(icache_rsp_ready, "R5 rsp ready", icache_rsp_ready, 1);
    step(); icache_rsp_valid = 0; #1;
    chk(warp_resume_valid == res, "R9 resume", warp_resume_valid, res);
    if (res) chk(warp_resume_wid == WID_W'(w), "R9 resume wid", warp_resume_wid, w);
    step(); #1;
    chk(ibuf_nonempty[w], "R5 buffer filled", ibuf_nonempty, 1 << w);
    if (chk_head) chk(head(w) == hpc, "R5 record by tag", head(w), hpc);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk); rst_n = 1; #1;
    // R1 reset state
    chk(sched_ready && !icache_req_valid, "R1 handshake", {sched_ready, icache_req_valid}, 2);
    chk(pending_fetches == 0 && fetch_latency_acc == 0 && decode_stall_count == 0,
        "R1 counters", pending_fetches, 0);
    chk(ibuf_nonempty == '0, "R1 buffers", ibuf_nonempty, 0);
    @(negedge clk);

    // Fill the tag table with warps 0..3
    for (int w = 0; w < 4; w++) fetch_one(w, 32'h1000 + w * 32'h40, 0, w);
    #1;
    chk(pending_fetches == 4, "R6 pending", pending_fetches, 4);
    chk(fetch_latency_acc == ACC_W'(exp_acc), "R7 acc", fetch_latency_acc, exp_acc);

    // R4: fifth record with the table full (fetch-stall flag set)
    sched_valid = 1; sched_wid = 3'd4; sched_pc = 32'h2000; sched_fetch_stall = 1; #1;
    chk(sched_ready && warp_suspend_valid, "R2 suspend w4", warp_suspend_valid, 1);
    step(); sched_valid = 0; #1;
    chk(!icache_req_valid, "R4 no request", icache_req_valid, 0);
    step(); #1;
    chk(!icache_req_valid && !sched_ready, "R4 backpressure",
        {icache_req_valid, sched_ready}, 0);
    icache_req_ready = 0;

    // R5: out-of-order response frees tag 2, held record reuses it
    icache_rsp_valid = 1; icache_rsp_tag = 2; #1;
    chk(icache_rsp_ready, "R5 rsp ready", icache_rsp_ready, 1);
    step(); icache_rsp_valid = 0; #1;
    chk(warp_resume_valid && warp_resume_wid == 3'd2, "R9 resume w2", warp_resume_wid, 2);
    chk(icache_req_valid && icache_req_tag == 2 && icache_req_addr == 32'h2000,
        "R5 tag reuse", icache_req_tag, 2);
    step(); #1;
    chk(head(2) == 32'h1080, "R5 record w2", head(2), 32'h1080);
    icache_req_ready = 1;
    step();

    respond(3, 3, 32'h10C0, 1, 1);
    respond(0, 0, 32'h1000, 1, 1);
    respond(1, 1, 32'h1040, 1, 1);
    respond(2, 4, 32'h2000, 0, 1);   // R9: fetch-stall record, no resume
    #1;
    chk(pending_fetches == 0, "R6 drained", pending_fetches, 0);
    ibuf_pop = 8'h1F; step(); ibuf_pop = '0; #1;
    chk(ibuf_nonempty == '0, "R10 pop all", ibuf_nonempty, 0);

    // R8 / R10: overfill warp 5's buffer
    fetch_one(5, 32'h3000, 0, 0);
    fetch_one(5, 32'h3004, 0, 1);
    fetch_one(5, 32'h3008, 0, 2);
    respond(0, 5, 32'h3000, 1, 1);
    respond(1, 5, 32'h3000, 1, 1);
    icache_rsp_valid = 1; icache_rsp_tag = 2; #1;
    step(); icache_rsp_valid = 0; #1;
    chk(!warp_resume_valid && !icache_rsp_ready, "R8 stall blocks",
        {warp_resume_valid, icache_rsp_ready}, 0);
    chk(decode_stall_count == 0, "R8 stall start", decode_stall_count, 0);
    step(); step(); step(); #1;
    chk(decode_stall_count == 3, "R8 stall count", decode_stall_count, 3);
    ibuf_pop[5] = 1; #1;
    chk(head(5) == 32'h3000, "R10 order 1", head(5), 32'h3000);
    step(); ibuf_pop = '0; #1;
    chk(warp_resume_valid && warp_resume_wid == 3'd5, "R9 resume after stall",
        warp_resume_valid, 1);
    step(); #1;
    chk(decode_stall_count == 4, "R8 stall end", decode_stall_count, 4);
    chk(head(5) == 32'h3004, "R10 order 2", head(5), 32'h3004);
    ibuf_pop[5] = 1; step(); #1;
    chk(head(5) == 32'h3008, "R10 order 3", head(5), 32'h3008);
    step(); ibuf_pop = '0; #1;
    chk(ibuf_nonempty == '0, "R10 empty", ibuf_nonempty, 0);
    chk(pending_fetches == 0, "R6 final", pending_fetches, 0);
    chk(fetch_latency_acc == ACC_W'(exp_acc), "R7 acc final", fetch_latency_acc, exp_acc);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule